// File: doc/BRIEF.md
# Microcode-Selectable Cycle Length Generator

This block paces a microprogrammed datapath from a fast base clock. Each microcycle lasts a programmable number of base-clock ticks. A 3-bit period code taken from the microinstruction picks the length from an 8-entry table of tick counts. In that way an operation with a short critical path, such as a logical op, gets a short cycle, and an operation with a carry chain or a branch gets a longer one. The block marks the last tick of every microcycle with a one-tick strobe that advances the sequencer. It also drives a phase signal for the two halves of the cycle.

When slow memory or I/O holds the wait line high at the moment a cycle would end, the block does not add a whole cycle. It extends the current cycle by a fixed unit of a few ticks, so an access can receive a fractional wait such as one and a half wait states. It tests the wait line again at the end of each unit. While the cycle runs past its programmed length, a busy output is high.

The table can only be written while reset is held. The state machine has three states:
- IDLE: the state during reset.
- COUNT: the programmed part of a cycle.
- EXTEND: a wait extension unit.

The transitions between them are:
- IDLE to COUNT, on the first tick after reset is released.
- COUNT to COUNT, at a boundary where wait is low (the cycle ends).
- COUNT to EXTEND, at a boundary where wait is high.
- EXTEND to EXTEND, when wait is still high at the end of a unit.
- EXTEND to COUNT, when wait is low at the end of a unit (the cycle ends).

Top module: `ucyc_len_gen`

## Requirements
- R1: Writes to the period table take effect only while `rst_n` is low; a written value below 2 is stored as 2; writes made with reset released leave the table unchanged.
- R2: While reset is held, all outputs are low. The first cycle starts on the first tick after release and uses the table entry for code 0.
- R3: A cycle's length in ticks equals the table entry for the code that was presented with `load` high on the end tick of the previous cycle.
- R4: `load` and `code` are ignored on any tick that is not a cycle-end tick. Without a new load, the last selected code keeps applying to later cycles.
- R5: `cyc_end` is high for exactly one tick, the last tick of each cycle.
- R6: `phase` is high for the first ceil(N/2) ticks of a cycle whose programmed length is N. It is low for the remaining ticks and during any extension.
- R7: If `wait_req` is high at a unit boundary, the cycle grows by HALF_TICKS ticks (default 2). This repeats at each following boundary, and the cycle ends at the first boundary where `wait_req` is low. `busy` is high exactly on the added ticks.
- R8: Each of the 8 codes (0 to 7) selects its own table entry independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast base clock |
| rst_n | input | 1 | Active-low synchronous reset; also opens the table for writing |
| cfg_we | input | 1 | Table write strobe (effective only during reset) |
| cfg_addr | input | 3 | Table entry to write |
| cfg_data | input | 4 | Tick count to write |
| code | input | 3 | Period code from the microinstruction |
| load | input | 1 | Marks `code` as valid for the next cycle |
| wait_req | input | 1 | Stretch request from slow memory or I/O |
| cyc_end | output | 1 | One-tick strobe on the last tick of a cycle |
| phase | output | 1 | High in the first half of the programmed cycle |
| busy | output | 1 | High while a cycle runs past its programmed length |

## Verification
On a single boundary tick, the block may have to take a new period code and also decide whether to stretch. If `wait_req` is high on that tick, the code offered with `load` must be ignored, and only the code presented at the real end tick counts. The bench holds `load` high with changing codes while it switches `wait_req` at pseudo-random times, so that load strobes land on stretched boundaries, on extension boundaries and on true end ticks. A behavioural tick model checks every output on every clock. A wrong capture shows up as a cycle of the wrong length in the following cycle.

// File: rtl/ucyc_len_pkg.sv
package ucyc_len_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_EXTEND = 2'd2
    } ucyc_state_e;
endpackage

// File: rtl/ucyc_period_table.sv
module ucyc_period_table #(
    parameter int NCODE = 8,
    parameter int TW    = 4,
    localparam int AW   = $clog2(NCODE)
) (
    input  logic          clk,
    input  logic          wr_open,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [TW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [TW-1:0] rdata
);
    localparam logic [TW-1:0] MIN_TICKS = TW'(2);

    logic [TW-1:0] ent [NCODE];
    logic [TW-1:0] wdata_c;

    // Entries shorter than two ticks would leave no room for the phase split.
    assign wdata_c = (wdata < MIN_TICKS) ? MIN_TICKS : wdata;

    for (genvar g = 0; g < NCODE; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (wr_open && we && (waddr == AW'(g))) begin
                ent[g] <= wdata_c;
            end
        end
    end

    assign rdata = ent[raddr];
endmodule

// File: rtl/ucyc_tick_counter.sv
module ucyc_tick_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= W'(1);
        end else begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/ucyc_cycle_fsm.sv
module ucyc_cycle_fsm
    import ucyc_len_pkg::*;
#(
    parameter int NCODE      = 8,
    parameter int TW         = 4,
    parameter int HALF_TICKS = 2,
    localparam int AW        = $clog2(NCODE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wait_req,
    input  logic          load,
    input  logic [AW-1:0] code,
    input  logic [TW-1:0] cnt,
    input  logic [TW-1:0] tab_rd,
    output logic [AW-1:0] tab_addr,
    output logic          restart,
    output logic          cyc_end,
    output logic          phase,
    output logic          busy,
    output logic [TW-1:0] per_q,
    output ucyc_state_e   st_q
);
    localparam logic [TW-1:0] UNIT = TW'(HALF_TICKS);

    ucyc_state_e   st_d;
    logic [AW-1:0] sel_q;
    logic [TW-1:0] unit_len;
    logic          at_bound;
    logic [TW:0]   half_up;

    assign unit_len = (st_q == ST_EXTEND) ? UNIT : per_q;
    assign at_bound = (cnt == unit_len);
    assign half_up  = ({1'b0, per_q} + (TW+1)'(1)) >> 1;

    // Next state and counter restart
    always_comb begin
        st_d    = st_q;
        restart = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                st_d    = ST_COUNT;
                restart = 1'b1;
            end
            ST_COUNT, ST_EXTEND: begin
                if (at_bound) begin
                    restart = 1'b1;
                    st_d    = wait_req ? ST_EXTEND : ST_COUNT;
                end
            end
            default: begin
                st_d    = ST_IDLE;
                restart = 1'b1;
            end
        endcase
    end

    // Outputs
    always_comb begin
        cyc_end  = (st_q != ST_IDLE) && at_bound && !wait_req;
        tab_addr = (cyc_end && load) ? code : sel_q;
        phase    = (st_q == ST_COUNT) && ({1'b0, cnt} <= half_up);
        busy     = (st_q == ST_EXTEND);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            sel_q <= '0;
            per_q <= TW'(2);
        end else begin
            st_q  <= st_d;
            sel_q <= tab_addr;
            if ((st_q == ST_IDLE) || cyc_end) begin
                per_q <= tab_rd;
            end
        end
    end
endmodule

// File: rtl/ucyc_len_gen.sv
module ucyc_len_gen
    import ucyc_len_pkg::*;
#(
    parameter int NCODE      = 8,
    parameter int TW         = 4,
    parameter int HALF_TICKS = 2,
    localparam int AW        = $clog2(NCODE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [TW-1:0] cfg_data,
    input  logic [AW-1:0] code,
    input  logic          load,
    input  logic          wait_req,
    output logic          cyc_end,
    output logic          phase,
    output logic          busy
);
    logic [TW-1:0] cnt_w;
    logic [TW-1:0] tab_rd_w;
    logic [AW-1:0] tab_addr_w;
    logic          restart_w;
    logic [TW-1:0] per_w;
    ucyc_state_e   st_w;

    ucyc_period_table #(.NCODE(NCODE), .TW(TW)) u_table (
        .clk     (clk),
        .wr_open (!rst_n),
        .we      (cfg_we),
        .waddr   (cfg_addr),
        .wdata   (cfg_data),
        .raddr   (tab_addr_w),
        .rdata   (tab_rd_w)
    );

    ucyc_tick_counter #(.W(TW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart_w),
        .cnt     (cnt_w)
    );

    ucyc_cycle_fsm #(.NCODE(NCODE), .TW(TW), .HALF_TICKS(HALF_TICKS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wait_req (wait_req),
        .load     (load),
        .code     (code),
        .cnt      (cnt_w),
        .tab_rd   (tab_rd_w),
        .tab_addr (tab_addr_w),
        .restart  (restart_w),
        .cyc_end  (cyc_end),
        .phase    (phase),
        .busy     (busy),
        .per_q    (per_w),
        .st_q     (st_w)
    );
endmodule

// File: rtl/ucyc_len_chk.sv
module ucyc_len_chk
    import ucyc_len_pkg::*;
#(
    parameter int TW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wait_req,
    input logic          cyc_end,
    input logic          phase,
    input logic          busy,
    input logic [TW-1:0] per,
    input ucyc_state_e   st
);
    a_r5_end_single: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_end |=> !cyc_end);

    a_r6_phase_opens_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_end |=> phase);

    a_r7_busy_leaves_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(cyc_end));

    a_r7_busy_needs_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wait_req));

    a_r1_period_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |-> (per >= TW'(2)));
endmodule

bind ucyc_len_gen ucyc_len_chk #(.TW(TW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wait_req (wait_req),
    .cyc_end  (cyc_end),
    .phase    (phase),
    .busy     (busy),
    .per      (per_w),
    .st       (st_w)
);

// File: tb/ucyc_len_gen_tb.sv
module ucyc_len_gen_tb;
    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [3:0] cfg_data = '0;
    logic [2:0] code = '0;
    logic       load = 1'b0;
    logic       wait_req = 1'b0;
    logic       cyc_end, phase, busy;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string cur_tag = "R2 reset";
    logic [15:0] lf = 16'hACE1;

    // behavioural model
    int m_tab [8];
    bit m_run = 1'b0;
    int m_pos = 0, m_lim = 0, m_per = 0, m_sel = 0;

    always #4 clk = ~clk;

    ucyc_len_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .code(code), .load(load), .wait_req(wait_req),
        .cyc_end(cyc_end), .phase(phase), .busy(busy)
    );

    task automatic chk(input string nm, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL [%s] %s got %0b expected %0b at %0t", cur_tag, nm, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            bit e_end, e_ph, e_bsy;
            e_end = m_run && (m_pos == m_lim) && !wait_req;
            e_ph  = m_run && (m_pos <= (m_per + 1) / 2);
            e_bsy = m_run && (m_pos > m_per);
            chk("cyc_end (R5)", cyc_end, e_end);
            chk("phase (R6)", phase, e_ph);
            chk("busy (R7)", busy, e_bsy);
            if (!rst_n) begin
                m_run = 1'b0;
                m_sel = 0;
                if (cfg_we) m_tab[cfg_addr] = (cfg_data < 2) ? 2 : int'(cfg_data);
            end else if (!m_run) begin
                m_run = 1'b1; m_pos = 1; m_per = m_tab[m_sel]; m_lim = m_per;
            end else if (m_pos == m_lim) begin
                if (wait_req) begin
                    m_lim += HALF; m_pos++;
                end else begin
                    if (load) m_sel = code;
                    m_per = m_tab[m_sel]; m_pos = 1; m_lim = m_per;
                end
            end else begin
                m_pos++;
            end
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        end
    endtask

    task automatic wr(input int a, input int d);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_data = 4'(d);
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        // R1 R2: table loaded during reset; entry 7 written below floor (clamped)
        step(2);
        cur_tag = "R1 R8 table load";
        wr(0, 5); wr(1, 3); wr(2, 4); wr(3, 6);
        wr(4, 7); wr(5, 9); wr(6, 12); wr(7, 1);
        step(2);
        cur_tag = "R2 first cycles use code 0";
        rst_n = 1'b1;
        step(30);
        // R8 R3: every code in turn, load held high
        cur_tag = "R3 R8 code sweep";
        load = 1'b1;
        for (int c = 0; c < 8; c++) begin
            code = 3'(c);
            step(40);
        end
        // R4: load and code change every tick, mostly off the end tick
        cur_tag = "R4 off-end loads";
        for (int i = 0; i < 300; i++) begin
            load = lf[0] & lf[5]; code = lf[4:2];
            step(1);
        end
        load = 1'b0; code = 3'd6;
        step(60);
        // R7: wait pulses and long holds together with loads
        cur_tag = "R7 wait stretch";
        for (int i = 0; i < 500; i++) begin
            wait_req = (i % 97 < 11) ? 1'b1 : (lf[1] & lf[7]);
            load = lf[3]; code = lf[10:8];
            step(1);
        end
        wait_req = 1'b0;
        step(20);
        // R1: writes with reset released must be ignored
        cur_tag = "R1 write ignored";
        wr(1, 15); wr(2, 0);
        load = 1'b1; code = 3'd1;
        step(40);
        code = 3'd2;
        step(40);
        // R1: same write under reset takes effect
        cur_tag = "R1 write in reset";
        rst_n = 1'b0;
        step(1);
        wr(1, 15);
        step(1);
        rst_n = 1'b1;
        code = 3'd1;
        step(80);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(8 * 60000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL [watchdog] run incomplete got hang expected finish");
            summary();
            $finish;
        end
    end
endmodule